// File: doc/BRIEF.md
# Synchronous Receive Input Conditioner

This block prepares the three external pins of a synchronous serial receiver before the receiver sees them. The pins are serial data, receive clock and carrier detect. The receive clock pin is brought into the system clock domain through a two-flop synchronizer. Its chosen edge becomes a one-cycle bit strobe. That strobe can be gated by the carrier-detect level, and the active level of the gate can be programmed. Received data can be inverted, and all three pins can be shut off together.

An 8-bit control register holds these settings and can be read back. Two mode inputs change the routing. In loop-back, the receiver takes the transmitter's own data and bit strobe, and the pin-related controls do not apply. In auto-echo, the raw pin levels are passed to the echo outputs without any conditioning.

Top module: `sicond_top`

## Requirements
- R1: After reset the control register reads 8'h03. A write with `ctrl_wr` high loads all eight bits of `ctrl_wdata`, and `ctrl_rdata` shows the new value from the next clock edge on. Bit fields: 7 mode enable, 6 data invert, 5 clock edge (1 = falling), 4 gate enable, 3 gate level (1 = active high), 2 input shutoff, 1:0 spare.
- R2: While bit 7 is 0, `rx_strobe` is 0 and `rx_data` is 1, whatever the other bits, the pins and `loop_mode` are.
- R3: While bit 7 is 1, bit 2 is 1 and `loop_mode` is 0, `rx_strobe` is 0 and `rx_data` is 1.
- R4: With the receive path active (bit 7 = 1, bit 2 = 0, `loop_mode` = 0), `rx_data` equals the `sin_pin` level sampled at the second-to-last clock edge, XOR bit 6.
- R5: On the active path with gating off, `rx_strobe` is high for exactly one cycle per selected edge of `rxclk_pin`. Bit 5 = 0 selects rising and 1 selects falling. The strobe occupies the cycle after the second system edge that samples the new level.
- R6: With bit 4 set, a strobe is produced only when carrier detect is at its active level. The level is taken from `dcd_pin` with the same synchronizer delay as the clock.
- R7: Bit 3 picks the active carrier-detect level: 0 means low is active, 1 means high is active.
- R8: With `loop_mode` = 1 and bit 7 = 1, `rx_data` equals `tx_data` and `rx_strobe` equals `tx_strobe` in the same cycle. Bits 6, 5, 4, 3 and 2 have no effect on this.
- R9: With `echo_mode` = 1, `echo_sout`, `echo_clkout` and `echo_rts` equal the raw `sin_pin`, `rxclk_pin` and `dcd_pin` with no conditioning, whatever the control register holds. With `echo_mode` = 0 these outputs rest at 1, 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write value |
| ctrl_rdata | output | 8 | Control register contents |
| sin_pin | input | 1 | Raw serial data pin |
| rxclk_pin | input | 1 | Raw receive clock pin |
| dcd_pin | input | 1 | Raw carrier-detect pin |
| echo_mode | input | 1 | Auto-echo routing select |
| loop_mode | input | 1 | Loop-back routing select |
| tx_data | input | 1 | Transmitter serial data for loop-back |
| tx_strobe | input | 1 | Transmitter bit strobe for loop-back |
| rx_data | output | 1 | Conditioned receive data |
| rx_strobe | output | 1 | Receive bit strobe, one system cycle |
| echo_sout | output | 1 | Echoed serial data |
| echo_clkout | output | 1 | Echoed receive clock |
| echo_rts | output | 1 | Echoed carrier detect |

## Verification
Results arrive at different times. The echo and loop-back outputs follow their inputs within the same cycle. Pin-derived data and gate levels appear two system edges after the pins are sampled. A clock-pin edge yields its strobe in the cycle after the second edge that samples the new level. A control write takes effect one edge after the strobe. The bench keeps a queue of pin levels taken at each rising edge and computes the expected outputs from the entries of the right age. It compares them at every falling edge, before it drives the next inputs, so each result is checked exactly in the cycle the requirements give for it.

// File: rtl/sicond_pkg.sv
package sicond_pkg;

  localparam int CTRL_W = 8;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h03;

  typedef struct packed {
    logic       sync_en;
    logic       data_inv;
    logic       clk_fall;
    logic       gate_en;
    logic       gate_high;
    logic       in_off;
    logic [1:0] spare;
  } sicond_ctrl_t;

  // Edge detect on a synchronized level: current sample against previous one.
  function automatic logic pick_edge(logic cur, logic prev, logic fall);
    return fall ? (prev & ~cur) : (cur & ~prev);
  endfunction

  // Carrier gate: open when gating is off or the level matches the active one.
  function automatic logic gate_open(logic en, logic lvl, logic active_high);
    return (!en) || (lvl == active_high);
  endfunction

endpackage

// File: rtl/sicond_ctrl_reg.sv
module sicond_ctrl_reg #(
  parameter int              W         = 8,
  parameter logic [W-1:0]    RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_VAL;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/sicond_sync.sv
module sicond_sync #(
  parameter int               WIDTH     = 3,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);
  localparam int DEPTH = STAGES + 1;

  logic [WIDTH-1:0] chain [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RESET_VAL;
          else        chain[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RESET_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/sicond_rx_path.sv
module sicond_rx_path
  import sicond_pkg::*;
(
  input  sicond_ctrl_t ctrl,
  input  logic         loop_mode,
  input  logic         sin_s,
  input  logic         clk_s,
  input  logic         clk_s_prev,
  input  logic         dcd_s,
  input  logic         tx_data,
  input  logic         tx_strobe,
  output logic         path_active,
  output logic         edge_rise,
  output logic         edge_fall,
  output logic         gate_ok,
  output logic         rx_data,
  output logic         rx_strobe
);
  logic edge_sel;

  assign path_active = ctrl.sync_en && !ctrl.in_off && !loop_mode;
  assign edge_rise   = pick_edge(clk_s, clk_s_prev, 1'b0);
  assign edge_fall   = pick_edge(clk_s, clk_s_prev, 1'b1);
  assign edge_sel    = ctrl.clk_fall ? edge_fall : edge_rise;
  assign gate_ok     = gate_open(ctrl.gate_en, dcd_s, ctrl.gate_high);

  always_comb begin
    rx_data   = 1'b1;
    rx_strobe = 1'b0;
    if (ctrl.sync_en) begin
      if (loop_mode) begin
        rx_data   = tx_data;
        rx_strobe = tx_strobe;
      end else if (!ctrl.in_off) begin
        rx_data   = sin_s ^ ctrl.data_inv;
        rx_strobe = edge_sel && gate_ok;
      end
    end
  end
endmodule

// File: rtl/sicond_echo.sv
module sicond_echo (
  input  logic echo_mode,
  input  logic sin_pin,
  input  logic rxclk_pin,
  input  logic dcd_pin,
  output logic echo_sout,
  output logic echo_clkout,
  output logic echo_rts
);
  assign echo_sout   = echo_mode ? sin_pin   : 1'b1;
  assign echo_clkout = echo_mode ? rxclk_pin : 1'b0;
  assign echo_rts    = echo_mode ? dcd_pin   : 1'b1;
endmodule

// File: rtl/sicond_top.sv
module sicond_top
  import sicond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              sin_pin,
  input  logic              rxclk_pin,
  input  logic              dcd_pin,
  input  logic              echo_mode,
  input  logic              loop_mode,
  input  logic              tx_data,
  input  logic              tx_strobe,
  output logic              rx_data,
  output logic              rx_strobe,
  output logic              echo_sout,
  output logic              echo_clkout,
  output logic              echo_rts
);
  localparam int PIN_N = 3;
  localparam int IDX_SIN = 0;
  localparam int IDX_CLK = 1;
  localparam int IDX_DCD = 2;
  localparam logic [PIN_N-1:0] PIN_IDLE = 3'b001;

  logic [CTRL_W-1:0] ctrl_q;
  sicond_ctrl_t      ctrl;
  logic [PIN_N-1:0]  pins_s;
  logic [PIN_N-1:0]  pins_s_prev;

  // Named internal events for the checker.
  logic path_active;
  logic edge_rise;
  logic edge_fall;
  logic gate_ok;
  logic dcd_lvl_s;

  sicond_ctrl_reg #(.W(CTRL_W), .RESET_VAL(CTRL_RESET)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_wdata), .q(ctrl_q)
  );

  assign ctrl       = sicond_ctrl_t'(ctrl_q);
  assign ctrl_rdata = ctrl_q;

  sicond_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({dcd_pin, rxclk_pin, sin_pin}),
    .q(pins_s), .q_prev(pins_s_prev)
  );

  assign dcd_lvl_s = pins_s[IDX_DCD];

  sicond_rx_path u_rx (
    .ctrl(ctrl), .loop_mode(loop_mode),
    .sin_s(pins_s[IDX_SIN]), .clk_s(pins_s[IDX_CLK]),
    .clk_s_prev(pins_s_prev[IDX_CLK]), .dcd_s(dcd_lvl_s),
    .tx_data(tx_data), .tx_strobe(tx_strobe),
    .path_active(path_active), .edge_rise(edge_rise), .edge_fall(edge_fall),
    .gate_ok(gate_ok), .rx_data(rx_data), .rx_strobe(rx_strobe)
  );

  sicond_echo u_echo (
    .echo_mode(echo_mode), .sin_pin(sin_pin), .rxclk_pin(rxclk_pin),
    .dcd_pin(dcd_pin), .echo_sout(echo_sout), .echo_clkout(echo_clkout),
    .echo_rts(echo_rts)
  );
endmodule

// File: rtl/sicond_chk.sv
module sicond_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_wr,
  input logic [7:0] ctrl_wdata,
  input logic [7:0] ctrl_rdata,
  input logic       sin_pin,
  input logic       rxclk_pin,
  input logic       dcd_pin,
  input logic       echo_mode,
  input logic       loop_mode,
  input logic       tx_data,
  input logic       tx_strobe,
  input logic       rx_data,
  input logic       rx_strobe,
  input logic       echo_sout,
  input logic       echo_clkout,
  input logic       echo_rts,
  input logic       edge_rise,
  input logic       edge_fall,
  input logic       dcd_lvl_s
);
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_rdata == $past(ctrl_wdata))); // R1

  AST_MODE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[7] |-> (!rx_strobe && rx_data)); // R2

  AST_INPUTS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[7] && ctrl_rdata[2] && !loop_mode) |-> (!rx_strobe && rx_data)); // R3

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_rise |=> !edge_rise); // R5

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_fall |=> !edge_fall); // R5

  AST_GATE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && !loop_mode && ctrl_rdata[4]) |-> (dcd_lvl_s == ctrl_rdata[3])); // R6

  AST_LOOP_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode && ctrl_rdata[7]) |-> (rx_data == tx_data && rx_strobe == tx_strobe)); // R8

  AST_ECHO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    echo_mode |-> (echo_sout == sin_pin && echo_clkout == rxclk_pin && echo_rts == dcd_pin)); // R9
endmodule

bind sicond_top sicond_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
  .ctrl_rdata(ctrl_rdata), .sin_pin(sin_pin), .rxclk_pin(rxclk_pin),
  .dcd_pin(dcd_pin), .echo_mode(echo_mode), .loop_mode(loop_mode),
  .tx_data(tx_data), .tx_strobe(tx_strobe), .rx_data(rx_data),
  .rx_strobe(rx_strobe), .echo_sout(echo_sout), .echo_clkout(echo_clkout),
  .echo_rts(echo_rts), .edge_rise(edge_rise), .edge_fall(edge_fall),
  .dcd_lvl_s(dcd_lvl_s)
);

// File: tb/sicond_top_tb_top.sv
`timescale 1ns/1ps
module sicond_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic [7:0] ctrl_rdata;
  logic       sin_pin = 1'b1, rxclk_pin = 1'b0, dcd_pin = 1'b0;
  logic       echo_mode = 1'b0, loop_mode = 1'b0;
  logic       tx_data = 1'b1, tx_strobe = 1'b0;
  logic       rx_data, rx_strobe, echo_sout, echo_clkout, echo_rts;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit stim_on = 1'b0;
  int stim_period = 3;
  int stim_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Reference state
  logic [7:0] ref_ctrl = 8'h03;
  bit qs[$], qc[$], qd[$];

  always #2 clk = ~clk;

  sicond_top dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .sin_pin(sin_pin), .rxclk_pin(rxclk_pin),
    .dcd_pin(dcd_pin), .echo_mode(echo_mode), .loop_mode(loop_mode),
    .tx_data(tx_data), .tx_strobe(tx_strobe), .rx_data(rx_data),
    .rx_strobe(rx_strobe), .echo_sout(echo_sout), .echo_clkout(echo_clkout),
    .echo_rts(echo_rts)
  );

  initial begin
    qs = {1'b1, 1'b1, 1'b1};
    qc = {1'b0, 1'b0, 1'b0};
    qd = {1'b0, 1'b0, 1'b0};
  end

  // Reference model: record pin history and register state at each rising edge.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      ref_ctrl = 8'h03;
      qs.push_back(1'b1); qc.push_back(1'b0); qd.push_back(1'b0);
    end else begin
      qs.push_back(sin_pin); qc.push_back(rxclk_pin); qd.push_back(dcd_pin);
      if (ctrl_wr) ref_ctrl = ctrl_wdata;
    end
    while (qs.size() > 4) begin
      void'(qs.pop_front()); void'(qc.pop_front()); void'(qd.pop_front());
    end
  end

  task automatic check(bit ok, string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // Compare on every falling edge, then drive the next pin values.
  always @(negedge clk) begin
    if (cycles >= 2) begin
      bit s2, s3, act_path, edge_hit, gate, exp_str, exp_dat;
      string rq_d, rq_s;
      s2 = qc[qc.size()-2]; s3 = qc[qc.size()-3];
      act_path = ref_ctrl[7] && !ref_ctrl[2] && !loop_mode;
      edge_hit = ref_ctrl[5] ? (!s2 && s3) : (s2 && !s3);
      gate = !ref_ctrl[4] || (qd[qd.size()-2] == ref_ctrl[3]);
      if (!ref_ctrl[7]) begin
        exp_dat = 1'b1; exp_str = 1'b0; rq_d = "R2"; rq_s = "R2";
      end else if (loop_mode) begin
        exp_dat = tx_data; exp_str = tx_strobe; rq_d = "R8"; rq_s = "R8";
      end else if (ref_ctrl[2]) begin
        exp_dat = 1'b1; exp_str = 1'b0; rq_d = "R3"; rq_s = "R3";
      end else begin
        exp_dat = qs[qs.size()-2] ^ ref_ctrl[6];
        exp_str = edge_hit && gate;
        rq_d = "R4";
        rq_s = !ref_ctrl[4] ? "R5" : (ref_ctrl[3] ? "R7" : "R6");
      end
      check(ctrl_rdata == ref_ctrl, "R1", "ctrl_rdata", ctrl_rdata, ref_ctrl);
      check(rx_data === exp_dat, rq_d, "rx_data", {7'd0, rx_data}, {7'd0, exp_dat});
      check(rx_strobe === exp_str, rq_s, "rx_strobe", {7'd0, rx_strobe}, {7'd0, exp_str});
      check({echo_sout, echo_clkout, echo_rts} ===
              (echo_mode ? {sin_pin, rxclk_pin, dcd_pin} : 3'b101),
            "R9", "echo", {5'd0, echo_sout, echo_clkout, echo_rts},
            echo_mode ? {5'd0, sin_pin, rxclk_pin, dcd_pin} : 8'h05);
      if (act_path) begin end
    end
    if (stim_on) begin
      stim_cnt++;
      lfsr = {lfsr[0], lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      if (stim_cnt % stim_period == 0) rxclk_pin = ~rxclk_pin;
      if (stim_cnt % 11 == 0) dcd_pin = ~dcd_pin;
      sin_pin   = lfsr[3];
      tx_data   = lfsr[7];
      tx_strobe = lfsr[9];
    end
  end

  task automatic write_ctrl(logic [7:0] v);
    @(negedge clk); #1;
    ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); #1;
    ctrl_wr = 1'b0;
  endtask

  task automatic set_modes(bit echo, bit loopb);
    @(negedge clk); #1;
    echo_mode = echo; loop_mode = loopb;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    run(4);                         // R1: reset value 03h compared each cycle
    stim_on = 1'b1;
    run(60);                        // R2: mode off with active pins
    write_ctrl(8'h7F); run(40);     // R2: every other bit set, still idle
    write_ctrl(8'h80); run(150);    // R4, R5 rising edge
    write_ctrl(8'hC0); run(100);    // R4 inverted data
    write_ctrl(8'hA0); run(100);    // R5 falling edge
    stim_period = 1; run(60);       // R5 fastest pin toggling
    stim_period = 2; run(60);
    stim_period = 3;
    write_ctrl(8'h90); run(150);    // R6 gate active low
    write_ctrl(8'h98); run(150);    // R7 gate active high
    write_ctrl(8'hB8); run(100);    // R7 with falling edge
    write_ctrl(8'h84); run(80);     // R3 inputs shut off
    set_modes(1'b1, 1'b0); run(80); // R9 echo while shut off
    write_ctrl(8'h80); run(80);     // R9 echo with active path
    set_modes(1'b0, 1'b1);
    write_ctrl(8'hFC); run(100);    // R8 loop-back ignores other bits
    write_ctrl(8'h80); run(60);     // R8
    set_modes(1'b1, 1'b1); run(60); // R8, R9 together
    write_ctrl(8'h00); run(60);     // R2 loop-back with mode off
    set_modes(1'b0, 1'b0);
    write_ctrl(8'h81); run(60);     // R1 spare bits loaded
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule